// File: doc/BRIEF.md
# Wide Bus Chained Byte Sender

This block turns a stream of bytes into 16-bit words for a wide parallel send path. Each transfer begins with a one-cycle start pulse that carries its width (wide or narrow) and its direction (send or receive). During a wide send, bytes are paired in arrival order: the first byte of a pair is the low half and the second is the high half. A word leaves through a valid/ready output only when both halves are present.

A wide send can end on an odd byte. That byte is then not padded or dropped. It stays in the output data latch and the chain flag goes high. When the next wide send begins, the held byte becomes the low half of its first word, and the first new byte fills the high half. Software can read the flag through a one-bit control port. Writing a one to the control port discards the held byte. A receive transfer or a narrow transfer also ends the chain. In a narrow send, each byte goes out alone, with the high-half enable low.

Top module: `chained_byte_sender`

## Requirements
- R1: When the final byte of a wide send (marked by `byte_last_i`) arrives without a partner, it is kept and `ctl_flag_o` reads 1 from the next cycle.
- R2: When the flag is set and the next wide send begins, its first byte produces a word whose low half (bits 7:0) is the held byte and whose high half (bits 15:8) is the new byte, with `word_hi_en_o` = 1. The flag is 0 afterwards.
- R3: `ctl_flag_o` always shows the chain flag, and it is 0 after reset.
- R4: A control write with `ctl_wdata_i` = 1 clears the flag and discards the held byte. A later wide send then starts a fresh pair.
- R5: A start pulse with `xfer_send_i` = 0 (receive) clears the flag. No byte is accepted while a receive transfer is active.
- R6: A start pulse with `xfer_wide_i` = 0 (narrow) clears the flag. In a narrow send, each byte leaves as one word with the byte in bits 7:0, bits 15:8 zero and `word_hi_en_o` = 0.
- R7: A control write with `ctl_wdata_i` = 0 leaves the flag unchanged.
- R8: If a clear write and an unpaired final byte arrive in the same cycle, the flag ends up set and the byte is held.
- R9: With the flag clear, a wide send pairs bytes strictly in order. An even-length send emits one word per pair and leaves the flag at 0.
- R10: While `word_valid_o` is high and `word_ready_i` is low, the output word holds steady and `byte_ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start_i | input | 1 | One-cycle pulse that opens a transfer |
| xfer_wide_i | input | 1 | Width of the new transfer: 1 = wide (16-bit), 0 = narrow |
| xfer_send_i | input | 1 | Direction of the new transfer: 1 = send, 0 = receive |
| byte_valid_i | input | 1 | Input byte present |
| byte_data_i | input | BYTE_W | Input byte |
| byte_last_i | input | 1 | Marks the final byte of the transfer |
| byte_ready_o | output | 1 | The block takes the byte in this cycle |
| word_valid_o | output | 1 | Output word present |
| word_data_o | output | 2*BYTE_W | Output word, high half in the upper bits |
| word_hi_en_o | output | 1 | The high half of the word carries data |
| word_ready_i | input | 1 | The sink takes the word |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 1 | Control write data; 1 clears the chain flag |
| ctl_flag_o | output | 1 | Chain flag readback |

## Verification
The assertions check on every cycle the rules that hold state from one cycle to the next: an unpaired final byte sets the flag, a clear write drops it unless an unpaired final byte arrives in the same cycle, receive and narrow starts end the chain, a zero write leaves the flag alone, and a stalled output word stays unchanged while the input is held off. The pairing of byte values across two separate transfers can only be shown by the bench's scenarios. The same holds for the low/high order inside a word, the fresh pairing after a discarded byte, and the zero-filled narrow words. Each of these scenarios compares the words it collects against values it computes itself.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    localparam int DEF_BYTE_W = 8;

    typedef struct packed {
        logic wide;
        logic send;
    } xfer_mode_t;

    localparam xfer_mode_t MODE_RESET = '{wide: 1'b0, send: 1'b0};

    typedef enum logic [1:0] {
        HOLD_EMPTY   = 2'd0,
        HOLD_PARTIAL = 2'd1,
        HOLD_CHAINED = 2'd2
    } hold_state_t;

    function automatic logic keeps_chain(input xfer_mode_t m);
        return m.wide && m.send;
    endfunction

endpackage

// File: rtl/cbs_hold.sv
module cbs_hold
    import cbs_pkg::*;
#(
    parameter int BYTE_W = DEF_BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  xfer_mode_t        start_mode_i,
    input  logic              acc_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              last_i,
    input  logic              clr_i,
    output logic              send_o,
    output logic              chain_o,
    output logic              emit_o,
    output logic              emit_pair_o,
    output logic [BYTE_W-1:0] emit_lo_o,
    output logic [BYTE_W-1:0] emit_hi_o
);

    xfer_mode_t        mode_q;
    hold_state_t       state_q, state_d;
    logic [BYTE_W-1:0] lo_q;
    logic              wide_acc;
    logic              set_ev;

    assign wide_acc    = acc_i && mode_q.wide;
    assign set_ev      = wide_acc && (state_q == HOLD_EMPTY) && last_i;
    assign send_o      = mode_q.send;
    assign chain_o     = (state_q == HOLD_CHAINED);
    assign emit_o      = acc_i && (!mode_q.wide || state_q != HOLD_EMPTY);
    assign emit_pair_o = mode_q.wide;
    assign emit_lo_o   = mode_q.wide ? lo_q : byte_i;
    assign emit_hi_o   = mode_q.wide ? byte_i : '0;

    always_comb begin
        state_d = state_q;
        if (start_i) begin
            if (!keeps_chain(start_mode_i) || state_q != HOLD_CHAINED)
                state_d = HOLD_EMPTY;
        end else if (wide_acc) begin
            if (state_q == HOLD_EMPTY)
                state_d = last_i ? HOLD_CHAINED : HOLD_PARTIAL;
            else
                state_d = HOLD_EMPTY;
        end
        // a clear write loses to an unpaired final byte in the same cycle
        if (clr_i && !set_ev && state_d == HOLD_CHAINED)
            state_d = HOLD_EMPTY;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_RESET;
            state_q <= HOLD_EMPTY;
            lo_q    <= '0;
        end else begin
            if (start_i)
                mode_q <= start_mode_i;
            state_q <= state_d;
            if (wide_acc && state_q == HOLD_EMPTY)
                lo_q <= byte_i;
        end
    end

    a_r1_odd_last_sets: assert property (@(posedge clk) disable iff (rst)
        set_ev |=> chain_o);

    a_r4_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_ev) |=> !chain_o);

    a_r5_r6_start_ends_chain: assert property (@(posedge clk) disable iff (rst)
        (start_i && !keeps_chain(start_mode_i)) |=> !chain_o);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set_ev && clr_i) |=> chain_o);

    a_r5_no_accept_rx: assert property (@(posedge clk) disable iff (rst)
        !mode_q.send |-> !acc_i);

endmodule

// File: rtl/cbs_out.sv
module cbs_out #(
    parameter int BYTE_W = cbs_pkg::DEF_BYTE_W,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] lo_i,
    input  logic [BYTE_W-1:0] hi_i,
    input  logic              pair_i,
    input  logic              ready_i,
    output logic              vld_o,
    output logic [WORD_W-1:0] data_o,
    output logic              pair_o,
    output logic              space_o
);

    assign space_o = !vld_o || ready_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o  <= 1'b0;
            data_o <= '0;
            pair_o <= 1'b0;
        end else begin
            if (load_i) begin
                vld_o  <= 1'b1;
                data_o <= {hi_i, lo_i};
                pair_o <= pair_i;
            end else if (ready_i) begin
                vld_o  <= 1'b0;
            end
        end
    end

    a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (vld_o && !ready_i) |=> (vld_o && $stable(data_o) && $stable(pair_o)));

    a_r10_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        load_i |-> space_o);

endmodule

// File: rtl/chained_byte_sender.sv
module chained_byte_sender
    import cbs_pkg::*;
#(
    parameter int BYTE_W = DEF_BYTE_W,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_start_i,
    input  logic              xfer_wide_i,
    input  logic              xfer_send_i,
    input  logic              byte_valid_i,
    input  logic [BYTE_W-1:0] byte_data_i,
    input  logic              byte_last_i,
    output logic              byte_ready_o,
    output logic              word_valid_o,
    output logic [WORD_W-1:0] word_data_o,
    output logic              word_hi_en_o,
    input  logic              word_ready_i,
    input  logic              ctl_wr_i,
    input  logic              ctl_wdata_i,
    output logic              ctl_flag_o
);

    xfer_mode_t        start_mode;
    logic              send_q;
    logic              space;
    logic              acc;
    logic              clr;
    logic              emit;
    logic              emit_pair;
    logic [BYTE_W-1:0] emit_lo;
    logic [BYTE_W-1:0] emit_hi;

    assign start_mode   = '{wide: xfer_wide_i, send: xfer_send_i};
    assign byte_ready_o = send_q && !xfer_start_i && space;
    assign acc          = byte_valid_i && byte_ready_o;
    assign clr          = ctl_wr_i && ctl_wdata_i;

    cbs_hold #(.BYTE_W(BYTE_W)) u_hold (
        .clk          (clk),
        .rst          (rst),
        .start_i      (xfer_start_i),
        .start_mode_i (start_mode),
        .acc_i        (acc),
        .byte_i       (byte_data_i),
        .last_i       (byte_last_i),
        .clr_i        (clr),
        .send_o       (send_q),
        .chain_o      (ctl_flag_o),
        .emit_o       (emit),
        .emit_pair_o  (emit_pair),
        .emit_lo_o    (emit_lo),
        .emit_hi_o    (emit_hi)
    );

    cbs_out #(.BYTE_W(BYTE_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .load_i  (emit),
        .lo_i    (emit_lo),
        .hi_i    (emit_hi),
        .pair_i  (emit_pair),
        .ready_i (word_ready_i),
        .vld_o   (word_valid_o),
        .data_o  (word_data_o),
        .pair_o  (word_hi_en_o),
        .space_o (space)
    );

    a_r7_zero_write_idle: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr_i && !ctl_wdata_i && !xfer_start_i && !acc) |=> $stable(ctl_flag_o));

    a_r10_input_stalled: assert property (@(posedge clk) disable iff (rst)
        (word_valid_o && !word_ready_i) |-> !byte_ready_o);

endmodule

// File: tb/tb_chained_byte_sender.sv
module tb_chained_byte_sender;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xfer_start_i = 1'b0, xfer_wide_i = 1'b0, xfer_send_i = 1'b0;
    logic        byte_valid_i = 1'b0, byte_last_i = 1'b0;
    logic [7:0]  byte_data_i = '0;
    logic        byte_ready_o, word_valid_o, word_hi_en_o;
    logic [15:0] word_data_o;
    logic        word_ready_i = 1'b1;
    logic        ctl_wr_i = 1'b0, ctl_wdata_i = 1'b0;
    logic        ctl_flag_o;

    int checks = 0;
    int errors = 0;
    logic [16:0] got_q[$];

    always #5 clk = ~clk;

    chained_byte_sender dut (
        .clk(clk), .rst(rst),
        .xfer_start_i(xfer_start_i), .xfer_wide_i(xfer_wide_i), .xfer_send_i(xfer_send_i),
        .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i), .byte_last_i(byte_last_i),
        .byte_ready_o(byte_ready_o),
        .word_valid_o(word_valid_o), .word_data_o(word_data_o), .word_hi_en_o(word_hi_en_o),
        .word_ready_i(word_ready_i),
        .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i), .ctl_flag_o(ctl_flag_o)
    );

    // collects each word that the next rising edge hands over
    always @(negedge clk) begin
        #1;
        if (!rst && word_valid_o && word_ready_i)
            got_q.push_back({word_hi_en_o, word_data_o});
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pop_word(input string req, input logic [16:0] exp);
        logic [16:0] w;
        if (got_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL %s actual=none expected=%h", req, exp);
        end else begin
            w = got_q.pop_front();
            check(req, {15'd0, w}, {15'd0, exp});
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start(input logic wide, input logic send);
        @(negedge clk);
        xfer_start_i = 1'b1; xfer_wide_i = wide; xfer_send_i = send;
        #1;
        check("R5 start cycle holds input", {31'd0, byte_ready_o}, 32'd0);
        @(negedge clk);
        xfer_start_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, input logic last);
        @(negedge clk);
        byte_valid_i = 1'b1; byte_data_i = d; byte_last_i = last;
        #1;
        while (!byte_ready_o) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        byte_valid_i = 1'b0; byte_last_i = 1'b0;
    endtask

    task automatic ctl_write(input logic v);
        @(negedge clk);
        ctl_wr_i = 1'b1; ctl_wdata_i = v;
        @(negedge clk);
        ctl_wr_i = 1'b0; ctl_wdata_i = 1'b0;
    endtask

    task automatic flag_is(input string req, input logic exp);
        #1;
        check(req, {31'd0, ctl_flag_o}, {31'd0, exp});
    endtask

    task automatic t_reset;
        @(negedge clk);
        #1;
        check("R3 flag after reset", {31'd0, ctl_flag_o}, 32'd0);
        check("R5 no accept after reset", {31'd0, byte_ready_o}, 32'd0);
        check("reset word_valid", {31'd0, word_valid_o}, 32'd0);
    endtask

    task automatic t_pair_order;
        start(1'b1, 1'b1);
        send_byte(8'h11, 1'b0);
        send_byte(8'h22, 1'b0);
        send_byte(8'h33, 1'b0);
        send_byte(8'h44, 1'b1);
        idle(2);
        pop_word("R9 first pair", {1'b1, 16'h2211});
        pop_word("R9 second pair", {1'b1, 16'h4433});
        check("R9 no extra word", got_q.size(), 32'd0);
        flag_is("R9 even send leaves flag clear", 1'b0);
    endtask

    task automatic t_chain;
        start(1'b1, 1'b1);
        send_byte(8'hA1, 1'b0);
        send_byte(8'hB2, 1'b0);
        send_byte(8'hC3, 1'b1);
        flag_is("R1 odd last sets flag", 1'b1);
        idle(2);
        pop_word("R1 leading pair", {1'b1, 16'hB2A1});
        check("R1 odd byte not emitted", got_q.size(), 32'd0);
        flag_is("R3 flag readback holds", 1'b1);
        start(1'b1, 1'b1);
        flag_is("R2 wide start keeps flag", 1'b1);
        send_byte(8'hD4, 1'b0);
        flag_is("R2 flag clears on pairing", 1'b0);
        send_byte(8'hE5, 1'b0);
        send_byte(8'hF6, 1'b1);
        idle(2);
        pop_word("R2 held byte low, new byte high", {1'b1, 16'hD4C3});
        pop_word("R2 following pair", {1'b1, 16'hF6E5});
        flag_is("R2 even remainder leaves flag clear", 1'b0);
    endtask

    task automatic t_clear_write;
        start(1'b1, 1'b1);
        send_byte(8'h5A, 1'b1);
        flag_is("R1 single byte sets flag", 1'b1);
        ctl_write(1'b0);
        flag_is("R7 zero write keeps flag", 1'b1);
        ctl_write(1'b1);
        flag_is("R4 one write clears flag", 1'b0);
        ctl_write(1'b0);
        flag_is("R4 control bit not sticky", 1'b0);
        start(1'b1, 1'b1);
        send_byte(8'h01, 1'b0);
        send_byte(8'h02, 1'b1);
        idle(2);
        pop_word("R4 held byte discarded", {1'b1, 16'h0201});
        check("R4 no extra word", got_q.size(), 32'd0);
    endtask

    task automatic t_rx_clear;
        start(1'b1, 1'b1);
        send_byte(8'h6B, 1'b1);
        flag_is("R1 set before receive", 1'b1);
        start(1'b1, 1'b0);
        flag_is("R5 receive clears flag", 1'b0);
        @(negedge clk);
        byte_valid_i = 1'b1; byte_data_i = 8'hEE;
        #1;
        check("R5 receive takes no byte", {31'd0, byte_ready_o}, 32'd0);
        @(negedge clk);
        byte_valid_i = 1'b0;
        start(1'b1, 1'b1);
        send_byte(8'h03, 1'b0);
        send_byte(8'h04, 1'b1);
        idle(2);
        pop_word("R5 fresh pair after receive", {1'b1, 16'h0403});
        check("R5 no extra word", got_q.size(), 32'd0);
    endtask

    task automatic t_narrow;
        start(1'b1, 1'b1);
        send_byte(8'h7C, 1'b1);
        flag_is("R1 set before narrow", 1'b1);
        start(1'b0, 1'b1);
        flag_is("R6 narrow start clears flag", 1'b0);
        send_byte(8'h77, 1'b0);
        send_byte(8'h88, 1'b1);
        idle(2);
        pop_word("R6 narrow word one", {1'b0, 16'h0077});
        pop_word("R6 narrow word two", {1'b0, 16'h0088});
        flag_is("R6 narrow odd end no flag", 1'b0);
    endtask

    task automatic t_set_wins;
        start(1'b1, 1'b1);
        @(negedge clk);
        byte_valid_i = 1'b1; byte_data_i = 8'h99; byte_last_i = 1'b1;
        ctl_wr_i = 1'b1; ctl_wdata_i = 1'b1;
        #1;
        check("R8 byte taken with clear", {31'd0, byte_ready_o}, 32'd1);
        @(negedge clk);
        byte_valid_i = 1'b0; byte_last_i = 1'b0; ctl_wr_i = 1'b0; ctl_wdata_i = 1'b0;
        flag_is("R8 set wins over clear", 1'b1);
        start(1'b1, 1'b1);
        send_byte(8'h10, 1'b1);
        idle(2);
        pop_word("R8 held byte survives", {1'b1, 16'h1099});
        flag_is("R8 flag clear after pairing", 1'b0);
    endtask

    task automatic t_backpressure;
        @(negedge clk);
        word_ready_i = 1'b0;
        start(1'b1, 1'b1);
        send_byte(8'h21, 1'b0);
        send_byte(8'h22, 1'b0);
        #1;
        check("R10 word waiting", {31'd0, word_valid_o}, 32'd1);
        check("R10 input stalled", {31'd0, byte_ready_o}, 32'd0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            check("R10 word held steady", {15'd0, word_hi_en_o, word_data_o}, {15'd0, 1'b1, 16'h2221});
            check("R10 stall persists", {31'd0, byte_ready_o}, 32'd0);
        end
        check("R10 nothing delivered", got_q.size(), 32'd0);
        @(negedge clk);
        word_ready_i = 1'b1;
        send_byte(8'h23, 1'b0);
        send_byte(8'h24, 1'b1);
        idle(2);
        pop_word("R10 stalled word delivered", {1'b1, 16'h2221});
        pop_word("R10 next word", {1'b1, 16'h2423});
        check("R10 no extra word", got_q.size(), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_pair_order();
        t_chain();
        t_clear_write();
        t_rx_clear();
        t_narrow();
        t_set_wins();
        t_backpressure();
        idle(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule